// File: doc/BRIEF.md
# Tempo Clock Pulse Multiplier

This block turns a slow stream of tempo strobes into a faster stream at an integer multiple of the same rate. A typical source is a 24-pulses-per-quarter-note beat clock that has already been decoded into single strobes. Typical factors run from about ten to about a hundred, and input rates go up to 100 strobes per second (250 BPM). The block counts system-clock cycles between consecutive input strobes. It divides that count by the requested factor and uses the quotient as the reload value of a down-counter. Each time that counter expires, the block emits one output strobe.

The block is open loop. It uses no phase detector. Every input strobe gives a fresh period measurement. The new spacing takes effect at once, and the output phase restarts on that strobe. A locked flag reports that a valid measurement exists. Before lock, and after the input has been absent for longer than the period counter can hold, the output stays silent.

Top module: `tempo_mult`

## Requirements
- R1: `pulse_in` passes through a two-flop synchronizer followed by rising-edge detection. An input held high for several cycles counts as one strobe. A strobe is detected at the second clock edge after the edge that first samples `pulse_in` high.
- R2: The measured period P is the number of system-clock cycles between two consecutive detected strobes.
- R3: The output interval is I = floor(P / F), where F is the factor input. A factor of 0 is treated as 1, and I is never less than 1. When F is a power of two, the quotient comes from a right shift and matches the division result exactly.
- R4: On a detected strobe that completes a valid measurement, `pulse_out` is high in the very next cycle, and the output phase restarts from that strobe.
- R5: After the strobe of R4, further output strobes follow every I cycles, with at most F-1 of them before the next input strobe. When I·F ≤ P, each input period therefore yields exactly F output strobes, evenly spaced.
- R6: A new input strobe discards any output strobes still pending and applies the new interval at once. When the new strobe falls on the same cycle as a counter expiry, exactly one output strobe is produced.
- R7: `locked` rises only on the second detected strobe after reset (or after loss of lock). `pulse_out` stays low before that.
- R8: The period counter saturates at 2^PERIOD_W-1. When it saturates, `locked` clears and output strobes stop. The next input strobe starts a fresh measurement and does not lock by itself.
- R9: Each output strobe is one system-clock cycle wide. Back-to-back strobes occur only when I = 1.
- R10: While reset is asserted, and in the first cycle after it, both `pulse_out` and `locked` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Slow tempo strobe, asynchronous to `clk` |
| factor | input | FACTOR_W | Multiplication factor; 0 is treated as 1 |
| pulse_out | output | 1 | Multiplied strobe, one cycle wide |
| locked | output | 1 | High while a valid period measurement is in use |

## Verification
The critical case is an input strobe that lands in the same cycle as an output-counter expiry that still has strobes pending. The bench provokes it by measuring a 90-cycle period at factor 3 (interval 30) and then sending the next strobe after only 60 cycles. That strobe coincides with the second scheduled expiry. The reference model must then see exactly one output strobe, with the new phase starting from the input strobe. A second overlap occurs at the saturation cycle, where loss of lock and the remaining countdown meet. The bench checks that no strobe leaks out there.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
    // Default period counter width: about 8.4M cycles, which covers a slow
    // tempo at a system clock of several tens of MHz.
    localparam int PERIOD_W_DEF = 23;
    // Default factor width: factors up to 127.
    localparam int FACTOR_W_DEF = 7;
    // Synchronizer depth.
    localparam int SYNC_DEF     = 2;
endpackage

// File: rtl/tcm_rise_detect.sv
module tcm_rise_detect #(
    parameter int STAGES = tcm_pkg::SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q, sync_d;
    logic              last_q, last_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = din;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_comb last_d = sync_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tcm_interval_calc.sv
module tcm_interval_calc #(
    parameter int PERIOD_W = tcm_pkg::PERIOD_W_DEF,
    parameter int FACTOR_W = tcm_pkg::FACTOR_W_DEF
) (
    input  logic [PERIOD_W-1:0] period,
    input  logic [FACTOR_W-1:0] fac,
    output logic [PERIOD_W-1:0] interval
);
    localparam int SH_W = (FACTOR_W > 1) ? $clog2(FACTOR_W) : 1;

    logic [SH_W-1:0]     shamt;
    logic [PERIOD_W-1:0] raw;

    always_comb begin
        shamt = '0;
        for (int i = 0; i < FACTOR_W; i++) begin
            if (fac[i]) shamt = SH_W'(i);
        end
        if ($onehot(fac)) raw = period >> shamt;
        else              raw = period / PERIOD_W'(fac);
        interval = (raw == '0) ? PERIOD_W'(1) : raw;
    end
endmodule

// File: rtl/tempo_mult.sv
module tempo_mult #(
    parameter int PERIOD_W = tcm_pkg::PERIOD_W_DEF,
    parameter int FACTOR_W = tcm_pkg::FACTOR_W_DEF,
    parameter int SYNC_N   = tcm_pkg::SYNC_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pulse_in,
    input  logic [FACTOR_W-1:0] factor,
    output logic                pulse_out,
    output logic                locked
);
    localparam logic [PERIOD_W-1:0] PER_MAX = '1;

    typedef struct packed {
        logic [PERIOD_W-1:0] per_cnt;
        logic [PERIOD_W-1:0] interval;
        logic [PERIOD_W-1:0] out_cnt;
        logic [FACTOR_W-1:0] remain;
        logic                seen;
        logic                locked;
        logic                pulse;
    } st_t;

    st_t                 st_d, st_q;
    logic                rise;
    logic                saturated;
    logic [FACTOR_W-1:0] fac_eff;
    logic [PERIOD_W-1:0] period;
    logic [PERIOD_W-1:0] quot;

    tcm_rise_detect #(.STAGES(SYNC_N)) u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pulse_in),
        .rise (rise)
    );

    assign saturated = (st_q.per_cnt == PER_MAX);
    assign period    = st_q.per_cnt + 1'b1;
    assign fac_eff   = (factor == '0) ? FACTOR_W'(1) : factor;

    tcm_interval_calc #(.PERIOD_W(PERIOD_W), .FACTOR_W(FACTOR_W)) u_div (
        .period  (period),
        .fac     (fac_eff),
        .interval(quot)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!saturated) st_d.per_cnt = st_q.per_cnt + 1'b1;

        if (rise) begin
            st_d.per_cnt = '0;
            st_d.seen    = 1'b1;
            if (st_q.seen && !saturated) begin
                st_d.locked   = 1'b1;
                st_d.pulse    = 1'b1;
                st_d.interval = quot;
                st_d.out_cnt  = quot - 1'b1;
                st_d.remain   = fac_eff - 1'b1;
            end else begin
                st_d.locked = 1'b0;
                st_d.remain = '0;
            end
        end else begin
            if (saturated) st_d.locked = 1'b0;
            if (st_q.out_cnt == '0) begin
                st_d.out_cnt = st_q.interval - 1'b1;
                if (st_q.locked && st_q.remain != '0) begin
                    st_d.pulse  = 1'b1;
                    st_d.remain = st_q.remain - 1'b1;
                end
            end else begin
                st_d.out_cnt = st_q.out_cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_out = st_q.pulse;
    assign locked    = st_q.locked;
endmodule

// File: rtl/tcm_checker.sv
module tcm_checker (
    input logic clk,
    input logic rst_n,
    input logic rise,
    input logic pulse_out,
    input logic locked
);
    logic [1:0] n_rise_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      n_rise_q <= 2'd0;
        else if (rise && n_rise_q != 2'd2) n_rise_q <= n_rise_q + 2'd1;
    end

    a_r1_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    a_r7_lock_after_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (n_rise_q == 2'd2));

    a_r4_rise_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && locked) |=> (pulse_out || !locked));

    a_r8_silent_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> locked);

    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!pulse_out && !locked));
endmodule

bind tempo_mult tcm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .pulse_out(pulse_out),
    .locked   (locked)
);

// File: tb/tempo_mult_tb.sv
module tempo_mult_tb;
    localparam int CLK_P = 10;
    localparam int PW    = 10;
    localparam int FW    = 7;
    localparam int MAXP  = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pulse_in = 1'b0;
    logic [FW-1:0] factor = '0;
    logic          pulse_out, locked;

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R10";

    always #(CLK_P/2) clk = ~clk;

    tempo_mult #(.PERIOD_W(PW), .FACTOR_W(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .factor(factor),
        .pulse_out(pulse_out), .locked(locked)
    );

    // behavioural reference: event times rather than counters
    int ph1, ph2, ph3;
    int edge_n = 0, last_rise = 0, seen = 0, mlock = 0;
    int mint = 1, next_emit = 0, rem = 0, exp_pulse = 0;

    always @(posedge clk) begin
        int f, p, i, since;
        bit r;
        if (!rst_n) begin
            ph1 = 0; ph2 = 0; ph3 = 0;
            last_rise = edge_n; seen = 0; mlock = 0; rem = 0; exp_pulse = 0;
        end else begin
            r     = (ph2 == 1) && (ph3 == 0);
            since = edge_n - last_rise - 1;
            f     = (factor == 0) ? 1 : int'(factor);
            exp_pulse = 0;
            if (r) begin
                if (seen && since < MAXP) begin
                    p = edge_n - last_rise;
                    i = p / f;
                    if (i < 1) i = 1;
                    mint = i; next_emit = edge_n + i; rem = f - 1;
                    exp_pulse = 1; mlock = 1;
                end else begin
                    mlock = 0; rem = 0;
                end
                seen = 1; last_rise = edge_n;
            end else begin
                if (mlock && rem > 0 && edge_n == next_emit) begin
                    exp_pulse = 1; rem--; next_emit += mint;
                end
                if (since >= MAXP) mlock = 0;
            end
            ph3 = ph2; ph2 = ph1; ph1 = int'(pulse_in);
        end
        edge_n++;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (pulse_out !== exp_pulse[0] || locked !== mlock[0]) begin
                errors++;
                $display("FAIL %s cycle %0d: pulse_out=%b locked=%b expected pulse_out=%0d locked=%0d",
                         cur_req, edge_n, pulse_out, locked, exp_pulse, mlock);
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic train(input int per, input int n, input int hold);
        for (int k = 0; k < n; k++) begin
            pulse_in = 1'b1;
            repeat (hold) @(negedge clk);
            pulse_in = 1'b0;
            repeat (per - hold) @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R10 pulse_out in reset", pulse_out, 1'b0);
        check("R10 locked in reset", locked, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 pulse_out after reset", pulse_out, 1'b0);

        cur_req = "R7"; factor = 7'd4;
        train(100, 1, 1);
        check("R7 no lock after one strobe", locked, 1'b0);
        cur_req = "R2 R4 R5"; train(100, 4, 1);
        check("R7 locked after two strobes", locked, 1'b1);

        cur_req = "R3 non-power-of-two"; factor = 7'd10; train(137, 3, 1);
        cur_req = "R3 power-of-two shift"; factor = 7'd32; train(250, 3, 1);

        cur_req = "R6 collision"; factor = 7'd3;
        train(90, 2, 1);
        train(60, 3, 1);

        cur_req = "R1 held input"; factor = 7'd5; train(80, 4, 4);
        cur_req = "R3 factor zero"; factor = 7'd0; train(50, 3, 1);
        cur_req = "R9 interval one"; factor = 7'd20; train(10, 4, 1);
        train(100, 1, 1);

        cur_req = "R8 saturation";
        repeat (1200) @(negedge clk);
        check("R8 lock lost after timeout", locked, 1'b0);
        check("R8 silent after timeout", pulse_out, 1'b0);
        factor = 7'd4; train(100, 1, 1);
        check("R8 no relock on single strobe", locked, 1'b0);
        cur_req = "R2 R4 R5 relock"; train(100, 3, 1);
        check("R8 relocked", locked, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule